// File: doc/BRIEF.md
# Motor Speed Anomaly Lock Detector

This block watches the commutation edges of a brushless motor and decides when the rotor behaves in a way that calls for a lock fault. It does not compute speed directly. It counts time ticks between consecutive commutation edges, which gives the electrical period. It then compares that period against limits that are worked out at elaboration from the tick rate. No divider is built in hardware.

Four conditions are checked:
- **Too fast:** the period is shorter than the limit that belongs to the selected top speed.
- **Sudden jump:** the previous period exceeds the current one by more than a selected factor, a sudden acceleration.
- **Too slow:** no edge arrives within the period that belongs to the selected minimum speed.
- **Repeated loss of sync:** the number of loss-of-sync pulses reaches a selected count.

Each condition reports through one registered event pulse. The pulse carries a cause vector that a fault manager decodes. A tick divider derives the measurement time base from the system clock.

Top module: `spdlk_monitor`

## Requirements
- R1: After reset `lock_evt` is 0 and `lock_cause` is 0. No period history exists, so the first commutation edge after reset reports nothing.
- R2: The measured period is the number of ticks between two consecutive accepted edges. An edge that starts a measurement reports nothing. With `en_fast` high, an edge whose period is less than floor(TICK_HZ / (250·(fast_sel+1))) sets `lock_cause[0]`.
- R3: With `en_fast` high, an edge sets `lock_cause[1]` when the period before it exceeds 2·(jump_sel+1) times its own period. This check needs two measured periods in a row.
- R4: With `en_slow` high, `lock_cause[2]` is set when floor(2·TICK_HZ / h) ticks pass without an edge. Here h is 1, 2, 4, 6, 10, 20, 30, 50 for `slow_sel` 0 to 7, which is the minimum speed in half-hertz. This repeats every such interval while no edge arrives. Each firing discards the period history, so the next edge only starts a measurement.
- R5: With `en_sync` high, loss-of-sync pulses are counted. The pulse numbered `sync_sel`+2 sets `lock_cause[3]`, and the count then starts again from zero.
- R6: While `en_sync` is low, the loss-of-sync count is held at zero and pulses are ignored. A later enable needs the full count again.
- R7: A cycle with `clr` high suppresses every event of that cycle. It also zeroes the loss-of-sync count and discards the period history.
- R8: An event appears in the cycle after the stimulus and lasts one cycle. `lock_evt` is high exactly when some cause bit is set. Causes raised in the same cycle share one event.
- R9: With `en_fast` low, bits 0 and 1 never fire, but periods are still measured and stored. With `en_slow` low, bit 2 never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Clears sync count and period history, masks events this cycle |
| comm_edge | input | 1 | One-cycle pulse per commutation edge |
| sync_lost | input | 1 | One-cycle pulse per loss-of-sync event |
| en_fast | input | 1 | Enables the too-fast and jump checks |
| en_slow | input | 1 | Enables the too-slow check |
| en_sync | input | 1 | Enables loss-of-sync counting |
| fast_sel | input | 4 | Top speed code, 250 Hz·(code+1) |
| jump_sel | input | 2 | Jump factor code, factor 2·(code+1) |
| slow_sel | input | 3 | Minimum speed code (see R4) |
| sync_sel | input | 3 | Loss-of-sync count code, count = code+2 |
| lock_evt | output | 1 | One-cycle lock event pulse |
| lock_cause | output | 4 | Cause bits: 0 fast, 1 jump, 2 slow, 3 sync |

## Verification
The final loss-of-sync pulse and a commutation edge can land in the same cycle. This is the case where a sync-count event and an edge-based speed fault coincide. The bench provokes it by driving the last required sync pulse and a too-short edge on the same clock. It then expects a single event whose cause vector holds both bit 3 and bit 0, followed by a quiet cycle. Clear colliding with a fault-causing edge is provoked the same way, and no event is expected in that case.

// File: rtl/spdlk_pkg.sv
package spdlk_pkg;

   localparam int CAUSE_W  = 4;
   localparam int C_FAST   = 0;
   localparam int C_JUMP   = 1;
   localparam int C_SLOW   = 2;
   localparam int C_SYNC   = 3;

   localparam int FSEL_W   = 4;
   localparam int JSEL_W   = 2;
   localparam int SSEL_W   = 3;
   localparam int YSEL_W   = 3;

   localparam int LIM_W    = 32;
   localparam int N_FAST   = 1 << FSEL_W;
   localparam int N_SLOW   = 1 << SSEL_W;

   // minimum speed per code, in half-hertz
   function automatic int half_hz(input int code);
      case (code)
         0:       return 1;
         1:       return 2;
         2:       return 4;
         3:       return 6;
         4:       return 10;
         5:       return 20;
         6:       return 30;
         default: return 50;
      endcase
   endfunction

   // period limit (ticks) below which speed exceeds 250*(k+1) Hz
   function automatic logic [N_FAST*LIM_W-1:0] fast_limits(input longint tick_hz);
      logic [N_FAST*LIM_W-1:0] t;
      t = '0;
      for (int k = 0; k < N_FAST; k++)
         t[k*LIM_W +: LIM_W] = LIM_W'(tick_hz / longint'(250 * (k + 1)));
      return t;
   endfunction

   // period limit (ticks) at which speed drops under the minimum
   function automatic logic [N_SLOW*LIM_W-1:0] slow_limits(input longint tick_hz);
      logic [N_SLOW*LIM_W-1:0] t;
      t = '0;
      for (int k = 0; k < N_SLOW; k++)
         t[k*LIM_W +: LIM_W] = LIM_W'((2 * tick_hz) / longint'(half_hz(k)));
      return t;
   endfunction

endpackage

// File: rtl/spdlk_tick.sv
module spdlk_tick #(
   parameter int DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   generate
      if (DIV == 1) begin : g_every
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign tick_o    = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] c_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          c_q <= '0;
            else if (c_q == LAST) c_q <= '0;
            else                 c_q <= c_q + CW'(1);
         end

         assign tick_o = (c_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/spdlk_period.sv
module spdlk_period
   import spdlk_pkg::*;
#(
   parameter int TICK_HZ = 40_000,
   parameter int PW      = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              edge_i,
   input  logic              clr_i,
   input  logic [FSEL_W-1:0] fast_sel,
   input  logic [JSEL_W-1:0] jump_sel,
   input  logic [SSEL_W-1:0] slow_sel,
   output logic              fast_o,
   output logic              jump_o,
   output logic              slow_o
);

   localparam logic [N_FAST*LIM_W-1:0] FAST_TAB = fast_limits(longint'(TICK_HZ));
   localparam logic [N_SLOW*LIM_W-1:0] SLOW_TAB = slow_limits(longint'(TICK_HZ));
   localparam int XW = PW + 4;

   logic [PW-1:0] cnt_q, prev_q, meas, fast_lim, slow_lim;
   logic          started_q, hist_q, wrap;
   logic [3:0]    factor;
   logic [XW-1:0] jump_prod;

   assign fast_lim  = FAST_TAB[int'(fast_sel)*LIM_W +: PW];
   assign slow_lim  = SLOW_TAB[int'(slow_sel)*LIM_W +: PW];
   assign meas      = cnt_q + PW'(tick_i);
   assign factor    = {1'b0, jump_sel, 1'b0} + 4'd2;
   assign jump_prod = XW'(meas) * XW'(factor);
   assign wrap      = tick_i && !edge_i && (cnt_q >= slow_lim - PW'(1));

   assign fast_o = edge_i && started_q && (meas < fast_lim);
   assign jump_o = edge_i && started_q && hist_q && (XW'(prev_q) > jump_prod);
   assign slow_o = wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         prev_q    <= '0;
         started_q <= 1'b0;
         hist_q    <= 1'b0;
      end else if (clr_i) begin
         cnt_q     <= '0;
         started_q <= 1'b0;
         hist_q    <= 1'b0;
      end else if (edge_i) begin
         cnt_q     <= '0;
         started_q <= 1'b1;
         if (started_q) begin
            prev_q <= meas;
            hist_q <= 1'b1;
         end
      end else if (wrap) begin
         cnt_q     <= '0;
         started_q <= 1'b0;
         hist_q    <= 1'b0;
      end else if (tick_i) begin
         cnt_q     <= cnt_q + PW'(1);
      end
   end

   AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_i && !clr_i |=> cnt_q == '0 && started_q) else $error("edge restart");   // R2
   AST_SLOW_DROPS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      slow_o && !clr_i |=> !started_q && !hist_q) else $error("slow history");      // R4
   AST_CLR_DROPS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !started_q && !hist_q) else $error("clr history");                  // R7

endmodule

// File: rtl/spdlk_sync.sv
module spdlk_sync
   import spdlk_pkg::*;
#(
   parameter int SEL_W = YSEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic             pulse_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             fire_o
);

   localparam int CW = $clog2((1 << SEL_W) + 2);

   logic [CW-1:0] cnt_q;
   logic          reached;

   assign reached = cnt_q >= (CW'(sel_i) + CW'(1));
   assign fire_o  = en_i && !clr_i && pulse_i && reached;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!en_i || clr_i) cnt_q <= '0;
      else if (pulse_i)        cnt_q <= reached ? '0 : cnt_q + CW'(1);
   end

   AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> cnt_q == '0) else $error("sync restart");   // R5
   AST_SYNC_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> cnt_q == '0) else $error("sync idle");       // R6

endmodule

// File: rtl/spdlk_monitor.sv
module spdlk_monitor
   import spdlk_pkg::*;
#(
   parameter int CLK_HZ  = 125_000_000,
   parameter int TICK_HZ = 40_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              comm_edge,
   input  logic              sync_lost,
   input  logic              en_fast,
   input  logic              en_slow,
   input  logic              en_sync,
   input  logic [FSEL_W-1:0] fast_sel,
   input  logic [JSEL_W-1:0] jump_sel,
   input  logic [SSEL_W-1:0] slow_sel,
   input  logic [YSEL_W-1:0] sync_sel,
   output logic              lock_evt,
   output logic [CAUSE_W-1:0] lock_cause
);

   localparam int TICK_DIV = CLK_HZ / TICK_HZ;
   localparam int PW       = $clog2(2 * TICK_HZ + 1);

   initial begin
      assert (TICK_HZ >= 4000) else $error("TICK_HZ too low for the fastest limit");
      assert (TICK_HZ < (1 << 29)) else $error("TICK_HZ too high for period width");
      assert (CLK_HZ % TICK_HZ == 0) else $error("CLK_HZ must be a multiple of TICK_HZ");
   end

   logic tick, fast_raw, jump_raw, slow_raw, sync_fire;
   logic [CAUSE_W-1:0] cause_d;

   spdlk_tick #(.DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   spdlk_period #(.TICK_HZ(TICK_HZ), .PW(PW)) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .edge_i   (comm_edge),
      .clr_i    (clr),
      .fast_sel (fast_sel),
      .jump_sel (jump_sel),
      .slow_sel (slow_sel),
      .fast_o   (fast_raw),
      .jump_o   (jump_raw),
      .slow_o   (slow_raw)
   );

   spdlk_sync #(.SEL_W(YSEL_W)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_sync),
      .clr_i   (clr),
      .pulse_i (sync_lost),
      .sel_i   (sync_sel),
      .fire_o  (sync_fire)
   );

   always_comb begin
      cause_d         = '0;
      cause_d[C_FAST] = fast_raw && en_fast && !clr;
      cause_d[C_JUMP] = jump_raw && en_fast && !clr;
      cause_d[C_SLOW] = slow_raw && en_slow && !clr;
      cause_d[C_SYNC] = sync_fire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_evt   <= 1'b0;
         lock_cause <= '0;
      end else begin
         lock_evt   <= |cause_d;
         lock_cause <= cause_d;
      end
   end

   AST_FAST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_fast |=> lock_cause[C_JUMP:C_FAST] == 2'b00) else $error("fast mask");  // R9
   AST_SLOW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_slow |=> !lock_cause[C_SLOW]) else $error("slow mask");                 // R9
   AST_SYNC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_sync |=> !lock_cause[C_SYNC]) else $error("sync mask");                 // R6
   AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !lock_evt) else $error("clr quiet");                                // R7

endmodule

// File: tb/spdlk_monitor_test.sv
`timescale 1ns/1ps
module spdlk_monitor_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0, comm_edge = 1'b0, sync_lost = 1'b0;
   logic       en_fast = 1'b0, en_slow = 1'b0, en_sync = 1'b0;
   logic [3:0] fast_sel = '0;
   logic [1:0] jump_sel = '0;
   logic [2:0] slow_sel = '0, sync_sel = '0;
   logic       lock_evt;
   logic [3:0] lock_cause;

   int  checks = 0, errors = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   spdlk_monitor #(.CLK_HZ(40_000), .TICK_HZ(40_000)) uut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .comm_edge(comm_edge), .sync_lost(sync_lost),
      .en_fast(en_fast), .en_slow(en_slow), .en_sync(en_sync), .fast_sel(fast_sel),
      .jump_sel(jump_sel), .slow_sel(slow_sel), .sync_sel(sync_sel),
      .lock_evt(lock_evt), .lock_cause(lock_cause)
   );

   // {period[15:0], en_fast, fast_sel[3:0], jump_sel[1:0], expected cause[3:0]}
   localparam int NV = 16;
   localparam logic [26:0] VEC [NV] = '{
      {16'd100, 1'b1, 4'd3,  2'd0, 4'b0000},
      {16'd60,  1'b1, 4'd3,  2'd0, 4'b0000},
      {16'd29,  1'b1, 4'd3,  2'd0, 4'b0011},
      {16'd39,  1'b1, 4'd3,  2'd0, 4'b0001},
      {16'd40,  1'b1, 4'd3,  2'd0, 4'b0000},
      {16'd100, 1'b1, 4'd3,  2'd0, 4'b0000},
      {16'd50,  1'b1, 4'd3,  2'd0, 4'b0000},
      {16'd200, 1'b1, 4'd3,  2'd3, 4'b0000},
      {16'd25,  1'b1, 4'd3,  2'd3, 4'b0001},
      {16'd400, 1'b1, 4'd3,  2'd3, 4'b0000},
      {16'd49,  1'b1, 4'd3,  2'd3, 4'b0010},
      {16'd500, 1'b0, 4'd3,  2'd0, 4'b0000},
      {16'd20,  1'b0, 4'd3,  2'd0, 4'b0000},
      {16'd45,  1'b1, 4'd3,  2'd0, 4'b0000},
      {16'd9,   1'b1, 4'd15, 2'd0, 4'b0011},
      {16'd10,  1'b1, 4'd15, 2'd0, 4'b0000}
   };

   task automatic chk(input string req, input logic [3:0] exp);
      checks++;
      if (lock_evt !== (exp != 4'b0) || lock_cause !== exp) begin
         errors++;
         $display("FAIL %s: evt=%0b cause=%b expected evt=%0b cause=%b",
                  req, lock_evt, lock_cause, (exp != 4'b0), exp);
      end
   endtask

   task automatic pulse_edge();
      @(negedge clk) comm_edge = 1'b1;
      @(negedge clk) comm_edge = 1'b0;
   endtask

   task automatic edge_after(input int t);
      repeat (t - 2) @(negedge clk);
      pulse_edge();
   endtask

   task automatic pulse_sync();
      @(negedge clk) sync_lost = 1'b1;
      @(negedge clk) sync_lost = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R8 watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 4'b0000);

      // first edge after reset only starts a measurement
      en_fast = 1'b1; fast_sel = 4'd15;
      pulse_edge();
      chk("R1 R2 first edge silent", 4'b0000);

      // vector table: speed limit, jump factor, enable masking
      pulse_clr();
      pulse_edge();
      chk("R7 R2 start edge after clr", 4'b0000);
      for (int i = 0; i < NV; i++) begin
         en_fast  = VEC[i][10];
         fast_sel = VEC[i][9:6];
         jump_sel = VEC[i][5:4];
         edge_after(int'(VEC[i][26:11]));
         chk($sformatf("R2 R3 R9 vector %0d", i), VEC[i][3:0]);
      end
      @(negedge clk);
      chk("R8 event one cycle", 4'b0000);

      // too slow: code 7 -> 1600 ticks
      en_fast = 1'b1; fast_sel = 4'd3; jump_sel = 2'd0;
      en_slow = 1'b1; slow_sel = 3'd7;
      pulse_clr();
      pulse_edge();
      repeat (1599) @(negedge clk);
      chk("R4 before slow limit", 4'b0000);
      @(negedge clk);
      chk("R4 slow limit reached", 4'b0100);
      repeat (1599) @(negedge clk);
      chk("R4 before repeat", 4'b0000);
      @(negedge clk);
      chk("R4 slow repeats", 4'b0100);
      edge_after(5);
      chk("R4 history dropped", 4'b0000);
      edge_after(100);
      chk("R4 measuring again", 4'b0000);
      en_slow = 1'b0; slow_sel = 3'd0;

      // loss of sync counting
      en_sync = 1'b1; sync_sel = 3'd1;
      pulse_sync(); chk("R5 sync 1 of 3", 4'b0000);
      pulse_sync(); chk("R5 sync 2 of 3", 4'b0000);
      pulse_sync(); chk("R5 sync 3 of 3", 4'b1000);
      sync_sel = 3'd7;
      begin
         bit early;
         early = 1'b0;
         for (int k = 0; k < 8; k++) begin
            pulse_sync();
            if (lock_evt !== 1'b0) early = 1'b1;
         end
         checks++;
         if (early) begin
            errors++;
            $display("FAIL R5 code 7 early fire: actual=1 expected=0");
         end
      end
      pulse_sync(); chk("R5 sync 9 of 9", 4'b1000);
      sync_sel = 3'd0;
      pulse_sync(); chk("R5 sync 1 of 2", 4'b0000);
      pulse_sync(); chk("R5 sync 2 of 2", 4'b1000);

      // disable zeroes and ignores
      sync_sel = 3'd1;
      pulse_sync(); pulse_sync();
      @(negedge clk) en_sync = 1'b0;
      @(negedge clk) en_sync = 1'b1;
      pulse_sync(); chk("R6 count zeroed 1", 4'b0000);
      pulse_sync(); chk("R6 count zeroed 2", 4'b0000);
      pulse_sync(); chk("R6 full count again", 4'b1000);
      en_sync = 1'b0;
      for (int k = 0; k < 4; k++) begin
         pulse_sync();
         chk("R6 ignored while off", 4'b0000);
      end
      en_sync = 1'b1;
      pulse_sync(); pulse_sync();
      chk("R6 after enable 2", 4'b0000);
      pulse_sync(); chk("R6 after enable 3", 4'b1000);

      // clear zeroes sync count
      pulse_sync(); pulse_sync();
      pulse_clr();
      chk("R7 clr quiet", 4'b0000);
      pulse_sync(); pulse_sync();
      chk("R7 sync count cleared", 4'b0000);
      pulse_sync(); chk("R7 sync after clr", 4'b1000);

      // clear colliding with a fault edge
      pulse_clr();
      pulse_edge();
      edge_after(50);
      chk("R7 setup", 4'b0000);
      repeat (8) @(negedge clk);
      clr = 1'b1; comm_edge = 1'b1;
      @(negedge clk) begin clr = 1'b0; comm_edge = 1'b0; end
      chk("R7 clr masks edge", 4'b0000);
      edge_after(10);
      chk("R7 restart after clr", 4'b0000);
      edge_after(10);
      chk("R7 R2 fast after restart", 4'b0001);

      // sync threshold and fast edge in one cycle
      pulse_clr();
      pulse_sync(); pulse_sync();
      pulse_edge();
      chk("R8 setup", 4'b0000);
      repeat (18) @(negedge clk);
      comm_edge = 1'b1; sync_lost = 1'b1;
      @(negedge clk) begin comm_edge = 1'b0; sync_lost = 1'b0; end
      chk("R8 combined causes", 4'b1001);
      @(negedge clk);
      chk("R8 combined one cycle", 4'b0000);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule